// File: doc/BRIEF.md
# Split Load/Store Queueing Unit

This block sits between address generation and a first-level data cache. Loads and stores arrive on two separate request inputs. Each kind goes into its own queue: a 12-slot load queue and a 32-slot store queue. A store that is twice the cache word width is cut into two word-sized halves. Each half takes its own store slot. Stores leave for the cache strictly in arrival order on a dedicated store port.

Loads leave on a dedicated load port, and they do not wait for older loads. A load only has to wait while some store that entered before it, and that targets the same word address, is still queued. The two cache ports can each carry one operation in the same clock, so up to two operations issue per cycle.

The cache reports the end of each issued load through a response input. A hit frees the load's slot. A miss hands the load back to the queue so that it is offered again later. Addresses are in units of one cache word (8 bytes), so two accesses overlap exactly when their word addresses are equal.

Top module: `lsq_unit`

## Requirements
- R1: After reset both queues are empty. `ld_ready` and `st_ready` are high, and `c0_valid` and `c1_valid` are low.
- R2: The store queue holds 32 word entries. A narrow store (`st_wide`=0) is accepted when at least one entry is free. `st_ready` is low when all 32 entries are taken.
- R3: The load queue holds 12 loads. `ld_ready` is low exactly when all 12 slots are occupied.
- R4: An accepted load takes the lowest-numbered free slot, and that slot number is its `c0_id`. In each cycle the load port offers the lowest-numbered load that is waiting and eligible, even when a load that is older or lower-numbered is held.
- R5: A wide store (`st_wide`=1) at word address A becomes two store entries, with address A and then A+1. It is accepted only when at least two entries are free; otherwise `st_ready` is low.
- R6: The store port presents the oldest queued store entry. The entry leaves on the cycle `c1_valid` and `c1_ready` are both high. Entries leave in arrival order, so the two halves of a wide store go out back to back.
- R7: A load is held while any store entry that arrived before it, or in the same cycle, has the load's address. It becomes eligible in the cycle after that entry leaves. Stores that arrive after the load never hold it.
- R8: A load handed over on the load port (`c0_valid` and `c0_ready` high) is not offered again until a response for its `c0_id` arrives. A response with `rsp_miss`=1 makes the load waiting again; with `rsp_miss`=0 it frees the slot.
- R9: A load and a store can both be handed to the cache in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 16 | Load word address |
| ld_ready | output | 1 | Load queue can take a load |
| st_valid | input | 1 | Store request present |
| st_wide | input | 1 | Store is double width and needs two entries |
| st_addr | input | 16 | Store word address (first half) |
| st_ready | output | 1 | Store queue has room for this store |
| c0_valid | output | 1 | Load port request |
| c0_addr | output | 16 | Load port word address |
| c0_id | output | 4 | Load slot number carried with the request |
| c0_ready | input | 1 | Cache takes the load port request |
| c1_valid | output | 1 | Store port request |
| c1_addr | output | 16 | Store port word address |
| c1_ready | input | 1 | Cache takes the store port request |
| rsp_valid | input | 1 | Load response present |
| rsp_id | input | 4 | Slot number of the responding load |
| rsp_miss | input | 1 | 1: retry the load, 0: load complete |

## Verification
The bench fills both queues while the cache ports are stalled. A design that miscounted free entries would then accept a wide store into a single remaining slot, or let the load queue overflow. Addresses are drawn from a small set so that loads often collide with stores. A design that ignored store age would either release a load over an older matching store, or hold it behind a younger one. A design that picked loads in order would stall behind a held low slot. Responses with misses are mixed in: a design that lost the sent state would offer a load twice, and one that mishandled a miss would never retry it.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic {
    LD_WAIT = 1'b0,
    LD_SENT = 1'b1
  } ld_state_e;
endpackage

// File: rtl/lsq_pick_first.sv
module lsq_pick_first #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lsq_store_queue.sv
module lsq_store_queue #(
  parameter int DEPTH = 32,
  parameter int AW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic                        push_wide,
  input  logic [AW-1:0]               push_addr,
  input  logic                        pop,
  output logic                        head_vld,
  output logic [AW-1:0]               head_addr,
  output logic [DEPTH-1:0]            vld_vec,
  output logic [DEPTH-1:0][AW-1:0]    addr_vec,
  output logic [DEPTH-1:0]            alloc_vec,
  output logic [DEPTH-1:0]            pop_vec,
  output logic [CW-1:0]               free_cnt
);
  logic [DEPTH-1:0]         vld_q, vld_d;
  logic [DEPTH-1:0][AW-1:0] addr_q, addr_d;
  logic [PW-1:0]            head_q, head_d, tail_q, tail_d, tail1;
  logic [CW-1:0]            cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  always_comb begin
    vld_d     = vld_q;
    addr_d    = addr_q;
    head_d    = head_q;
    tail_d    = tail_q;
    alloc_vec = '0;
    pop_vec   = '0;
    tail1     = bump(tail_q);
    if (pop) begin
      vld_d[head_q]   = 1'b0;
      pop_vec[head_q] = 1'b1;
      head_d          = bump(head_q);
    end
    if (push) begin
      vld_d[tail_q]     = 1'b1;
      addr_d[tail_q]    = push_addr;
      alloc_vec[tail_q] = 1'b1;
      if (push_wide) begin
        vld_d[tail1]     = 1'b1;
        addr_d[tail1]    = push_addr + AW'(1);
        alloc_vec[tail1] = 1'b1;
        tail_d           = bump(tail1);
      end else begin
        tail_d = tail1;
      end
    end
    cnt_d = cnt_q + CW'(push) + CW'(push && push_wide) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (push || pop) begin
      vld_q  <= vld_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) addr_q <= addr_d;
  end

  assign head_vld  = vld_q[head_q];
  assign head_addr = addr_q[head_q];
  assign vld_vec   = vld_q;
  assign addr_vec  = addr_q;
  assign free_cnt  = CW'(DEPTH) - cnt_q;

  a_r2_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < CW'(DEPTH));
  a_r5_wide_two_free: assert property (@(posedge clk) disable iff (!rst_n)
    push && push_wide |-> cnt_q <= CW'(DEPTH - 2));
  a_r6_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> vld_q[head_q] && cnt_q != '0);
  a_r6_head_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> head_q == bump($past(head_q)));
endmodule

// File: rtl/lsq_load_queue.sv
module lsq_load_queue #(
  parameter int LQ  = 12,
  parameter int SQ  = 32,
  parameter int AW  = 16,
  localparam int IW = $clog2(LQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [SQ-1:0]            push_older,
  input  logic [SQ-1:0]            sq_vld,
  input  logic [SQ-1:0][AW-1:0]    sq_addr,
  input  logic [SQ-1:0]            sq_pop_vec,
  input  logic                     iss_ready,
  input  logic                     rsp_valid,
  input  logic [IW-1:0]            rsp_id,
  input  logic                     rsp_miss,
  output logic                     has_room,
  output logic                     iss_valid,
  output logic [AW-1:0]            iss_addr,
  output logic [IW-1:0]            iss_id
);
  import lsq_pkg::*;

  logic [LQ-1:0]           vld_q, vld_d;
  ld_state_e               st_q [LQ];
  ld_state_e               st_d [LQ];
  logic [LQ-1:0][AW-1:0]   addr_q, addr_d;
  logic [LQ-1:0][SQ-1:0]   older_q, older_d;
  logic [LQ-1:0]           blk, elig;
  logic [IW-1:0]           free_id;

  for (genvar i = 0; i < LQ; i++) begin : g_ent
    logic [SQ-1:0] hit;
    for (genvar j = 0; j < SQ; j++) begin : g_cmp
      assign hit[j] = sq_vld[j] && (sq_addr[j] == addr_q[i]);
    end
    assign blk[i]  = |(older_q[i] & hit);
    assign elig[i] = vld_q[i] && (st_q[i] == LD_WAIT) && !blk[i];
  end

  lsq_pick_first #(.N(LQ), .IW(IW)) u_pick_iss (
    .req(elig), .found(iss_valid), .idx(iss_id)
  );
  lsq_pick_first #(.N(LQ), .IW(IW)) u_pick_free (
    .req(~vld_q), .found(has_room), .idx(free_id)
  );

  assign iss_addr = addr_q[iss_id];

  always_comb begin
    vld_d  = vld_q;
    st_d   = st_q;
    addr_d = addr_q;
    for (int i = 0; i < LQ; i++) older_d[i] = older_q[i] & ~sq_pop_vec;
    if (rsp_valid) begin
      if (rsp_miss) st_d[rsp_id]  = LD_WAIT;
      else          vld_d[rsp_id] = 1'b0;
    end
    if (iss_valid && iss_ready) st_d[iss_id] = LD_SENT;
    if (push) begin
      vld_d[free_id]   = 1'b1;
      st_d[free_id]    = LD_WAIT;
      addr_d[free_id]  = push_addr;
      older_d[free_id] = push_older;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      older_q <= '0;
      for (int i = 0; i < LQ; i++) st_q[i] <= LD_WAIT;
    end else begin
      vld_q   <= vld_d;
      older_q <= older_d;
      st_q    <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) addr_q <= addr_d;
  end

  a_r3_push_has_slot: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !(&vld_q));
  a_r4_offer_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> vld_q[iss_id]);
  a_r8_rsp_to_sent: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> vld_q[rsp_id] && st_q[rsp_id] == LD_SENT);
  a_r8_handed_marked_sent: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready |=> st_q[$past(iss_id)] == LD_SENT);
endmodule

// File: rtl/lsq_unit.sv
module lsq_unit #(
  parameter int LQ_DEPTH = 12,
  parameter int SQ_DEPTH = 32,
  parameter int AW       = 16,
  localparam int IW      = $clog2(LQ_DEPTH),
  localparam int CW      = $clog2(SQ_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_ready,
  input  logic          st_valid,
  input  logic          st_wide,
  input  logic [AW-1:0] st_addr,
  output logic          st_ready,
  output logic          c0_valid,
  output logic [AW-1:0] c0_addr,
  output logic [IW-1:0] c0_id,
  input  logic          c0_ready,
  output logic          c1_valid,
  output logic [AW-1:0] c1_addr,
  input  logic          c1_ready,
  input  logic          rsp_valid,
  input  logic [IW-1:0] rsp_id,
  input  logic          rsp_miss
);
  logic [1:0]                    rsync_q;
  logic                          rst_s_n;
  logic                          ld_acc, st_acc, st_pop;
  logic [SQ_DEPTH-1:0]           sq_vld, sq_alloc, sq_popv;
  logic [SQ_DEPTH-1:0][AW-1:0]   sq_addr;
  logic [CW-1:0]                 sq_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  assign st_ready = st_wide ? (sq_free >= CW'(2)) : (sq_free != '0);
  assign st_acc   = st_valid && st_ready;
  assign ld_acc   = ld_valid && ld_ready;
  assign st_pop   = c1_valid && c1_ready;

  lsq_store_queue #(.DEPTH(SQ_DEPTH), .AW(AW)) u_sq (
    .clk(clk), .rst_n(rst_s_n),
    .push(st_acc), .push_wide(st_wide), .push_addr(st_addr), .pop(st_pop),
    .head_vld(c1_valid), .head_addr(c1_addr),
    .vld_vec(sq_vld), .addr_vec(sq_addr),
    .alloc_vec(sq_alloc), .pop_vec(sq_popv), .free_cnt(sq_free)
  );

  lsq_load_queue #(.LQ(LQ_DEPTH), .SQ(SQ_DEPTH), .AW(AW)) u_lq (
    .clk(clk), .rst_n(rst_s_n),
    .push(ld_acc), .push_addr(ld_addr),
    .push_older((sq_vld & ~sq_popv) | sq_alloc),
    .sq_vld(sq_vld), .sq_addr(sq_addr), .sq_pop_vec(sq_popv),
    .iss_ready(c0_ready),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_miss(rsp_miss),
    .has_room(ld_ready),
    .iss_valid(c0_valid), .iss_addr(c0_addr), .iss_id(c0_id)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_s_n |-> !c0_valid && !c1_valid);
  a_r6_store_held_when_stalled: assert property (@(posedge clk) disable iff (!rst_s_n)
    c1_valid && !c1_ready |=> c1_valid && $stable(c1_addr));
endmodule

// File: tb/tb_lsq_unit.sv
module tb_lsq_unit;
  localparam int LQ = 12;
  localparam int SQ = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, st_valid, st_wide, c0_ready, c1_ready, rsp_valid, rsp_miss;
  logic [15:0] ld_addr, st_addr;
  logic [3:0]  rsp_id;
  logic        ld_ready, st_ready, c0_valid, c1_valid;
  logic [15:0] c0_addr, c1_addr;
  logic [3:0]  c0_id;

  int n_cmp = 0;
  int n_bad = 0;

  bit m_busy [LQ];
  bit m_sent [LQ];
  int m_addr [LQ];
  int m_bar  [LQ];
  int q_a[$];
  int q_s[$];
  int serial = 0;
  int cov_both = 0, cov_lq_full = 0, cov_wide_stall = 0, cov_ooo = 0, cov_miss = 0;

  always #2.5 clk = ~clk;

  lsq_unit dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
    .st_valid(st_valid), .st_wide(st_wide), .st_addr(st_addr), .st_ready(st_ready),
    .c0_valid(c0_valid), .c0_addr(c0_addr), .c0_id(c0_id), .c0_ready(c0_ready),
    .c1_valid(c1_valid), .c1_addr(c1_addr), .c1_ready(c1_ready),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_miss(rsp_miss)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit held(input int i);
    for (int k = 0; k < q_a.size(); k++)
      if (q_s[k] <= m_bar[i] && q_a[k] == m_addr[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input int p_ld, input int p_st, input int p_wide, input int p_c0,
                      input int p_c1, input int p_rsp, input int p_miss);
    int free_id, pick, first_held;
    bit e_ldr, e_str, e_c1v;
    int sent_ids[$];
    @(negedge clk);
    ld_valid = ($urandom_range(99) < p_ld);
    ld_addr  = 16'($urandom_range(7));
    st_valid = ($urandom_range(99) < p_st);
    st_wide  = ($urandom_range(99) < p_wide);
    st_addr  = 16'($urandom_range(6));
    c0_ready = ($urandom_range(99) < p_c0);
    c1_ready = ($urandom_range(99) < p_c1);
    for (int i = 0; i < LQ; i++) if (m_busy[i] && m_sent[i]) sent_ids.push_back(i);
    rsp_valid = (sent_ids.size() > 0) && ($urandom_range(99) < p_rsp);
    rsp_id    = '0;
    rsp_miss  = 1'b0;
    if (rsp_valid) begin
      rsp_id   = 4'(sent_ids[$urandom_range(sent_ids.size() - 1)]);
      rsp_miss = ($urandom_range(99) < p_miss);
    end
    #1;
    free_id = -1;
    for (int i = 0; i < LQ; i++) if (!m_busy[i] && free_id < 0) free_id = i;
    e_ldr = (free_id >= 0);
    e_str = st_wide ? ((SQ - q_a.size()) >= 2) : (q_a.size() < SQ);
    e_c1v = (q_a.size() > 0);
    pick = -1;
    first_held = -1;
    for (int i = 0; i < LQ; i++) begin
      if (m_busy[i] && !m_sent[i]) begin
        if (held(i)) begin
          if (first_held < 0) first_held = i;
        end else if (pick < 0) pick = i;
      end
    end
    chk("R3", "ld_ready", int'(ld_ready), int'(e_ldr));
    chk("R2 R5", "st_ready", int'(st_ready), int'(e_str));
    chk("R6", "c1_valid", int'(c1_valid), int'(e_c1v));
    if (e_c1v) chk("R6", "c1_addr", int'(c1_addr), q_a[0]);
    chk("R7 R8", "c0_valid", int'(c0_valid), int'(pick >= 0));
    if (pick >= 0) begin
      chk("R4", "c0_id", int'(c0_id), pick);
      chk("R4", "c0_addr", int'(c0_addr), m_addr[pick]);
    end
    if (!e_ldr) cov_lq_full++;
    if (st_valid && st_wide && !e_str && q_a.size() < SQ) cov_wide_stall++;
    if (pick >= 0 && first_held >= 0 && first_held < pick) cov_ooo++;
    if (pick >= 0 && c0_ready && e_c1v && c1_ready) cov_both++;
    if (rsp_valid && rsp_miss) cov_miss++;
    if (e_c1v && c1_ready) begin
      void'(q_a.pop_front());
      void'(q_s.pop_front());
    end
    if (rsp_valid) begin
      if (rsp_miss) m_sent[rsp_id] = 1'b0;
      else          m_busy[rsp_id] = 1'b0;
    end
    if (pick >= 0 && c0_ready) m_sent[pick] = 1'b1;
    if (st_valid && e_str) begin
      q_a.push_back(int'(st_addr));
      q_s.push_back(serial);
      serial++;
      if (st_wide) begin
        q_a.push_back(int'(16'(st_addr + 16'd1)));
        q_s.push_back(serial);
        serial++;
      end
    end
    if (ld_valid && e_ldr) begin
      m_busy[free_id] = 1'b1;
      m_sent[free_id] = 1'b0;
      m_addr[free_id] = int'(ld_addr);
      m_bar[free_id]  = serial - 1;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 0; st_valid = 0; st_wide = 0; c0_ready = 0; c1_ready = 0;
    rsp_valid = 0; rsp_miss = 0; rsp_id = '0; ld_addr = '0; st_addr = '0;
    for (int i = 0; i < LQ; i++) begin
      m_busy[i] = 0; m_sent[i] = 0; m_addr[i] = 0; m_bar[i] = -1;
    end
    repeat (3) @(negedge clk);
    chk("R1", "c0_valid in reset", int'(c0_valid), 0);
    chk("R1", "c1_valid in reset", int'(c1_valid), 0);
    chk("R1", "ld_ready in reset", int'(ld_ready), 1);
    chk("R1", "st_ready in reset", int'(st_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "c0_valid after reset", int'(c0_valid), 0);
    chk("R1", "ld_ready after reset", int'(ld_ready), 1);
    repeat (150)  step(90, 90, 50, 0, 0, 0, 0);
    repeat (150)  step(20, 10, 30, 100, 0, 0, 0);
    repeat (100)  step(10, 10, 80, 100, 30, 60, 20);
    repeat (3000) step(50, 50, 30, 70, 60, 50, 30);
    repeat (300)  step(0, 0, 0, 100, 100, 100, 0);
    chk("R3", "load queue seen full", int'(cov_lq_full > 0), 1);
    chk("R5", "wide store stalled with one slot free", int'(cov_wide_stall > 0), 1);
    chk("R4", "load issued past a held lower slot", int'(cov_ooo > 0), 1);
    chk("R8", "miss responses exercised", int'(cov_miss > 0), 1);
    chk("R9", "load and store handed over in one cycle", int'(cov_both > 0), 1);
    chk("R6", "store queue drained", int'(c1_valid), 0);
    summary();
  end
endmodule